// File: doc/BRIEF.md
# Serial Peripheral Slave with Completion and Collision Flags

This block is a clocked SPI slave for a host processor. The pins SCK, active-low select and MOSI come from an external master. Each is brought into the system clock domain through a two-flop synchroniser. SCK edges are then detected there, so the system clock must run at least four times faster than SCK. Each character is full duplex: on every sampling edge the slave takes one MOSI bit, and it presents one transmit bit on MISO. MISO is driven only while the slave is selected.

On the host side there are two registers, chosen by a one-bit address. Address 0 is the data register. A write loads the transmit buffer, and a read returns the last received character. Address 1 is the status register. A character that ends sets a completion flag. The flag stays set until the host reads the status register and then accesses the data register. A data write while the slave is selected is a collision. Such a write is dropped and sets a collision flag. An interrupt output follows the two flags. Clock polarity, clock phase and the 8/16-bit character length are static configuration inputs.

Top module: `spi_slave_flags`

## Requirements
- R1: `miso_oe_o` is 1 only while the synchronised select is asserted (low). Once `ssel_ni` has been high for three clocks, `miso_oe_o` is 0 and `miso_o` equals the idle level `IDLE_BIT`.
- R2: Bits are sampled from MOSI MSB first. A completed character appears in the data register (address 0) right-aligned. In 8-bit mode the upper bits read as zero.
- R3: The leading edge is the SCK transition away from the idle level `cfg_cpol_i`. With `cfg_cpha_i`=0 the slave samples on leading edges and changes MISO on trailing edges; with `cfg_cpha_i`=1 this is reversed. The first MISO bit is valid before the first sampling edge in all four modes.
- R4: A character has 16 bits when `cfg_wide_i`=1 and 8 bits otherwise. The completion flag sets on the sampling edge of the last bit, and not before.
- R5: The completion flag is status bit 0. It stays set until a status read that returns a flag set is followed by a data-register access. A data access with no such status read before it leaves the flag set.
- R6: A data write while selected sets the collision flag (status bit 1). The write is dropped: the character in flight and the transmit buffer are unchanged.
- R7: The collision flag is cleared by the same status-read-then-data-access sequence as the completion flag.
- R8: A word written while deselected is shifted out MSB first in the next character; in 8-bit mode its low byte is sent. If no word is pending, MISO sends `IDLE_BIT` for every bit.
- R9: If select rises before the last bit of a character, the partial character is discarded. No flag is set, and the next character starts again at bit 0.
- R10: `irq_o` is high exactly when the completion flag or the collision flag is set.
- R11: With select held low across characters, each character sets the completion flag. A later character with no new word sends the idle value.
- R12: After reset both flags are clear, `irq_o` is 0, the data register reads 0 and MISO is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cpol_i | input | 1 | SCK idle level |
| cfg_cpha_i | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_wide_i | input | 1 | 1: 16-bit characters; 0: 8-bit |
| sck_i | input | 1 | Serial clock from master |
| ssel_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | MISO output enable |
| host_req_i | input | 1 | Host access strobe, one cycle per access |
| host_we_i | input | 1 | Host write when 1 |
| host_addr_i | input | 1 | 0: data register; 1: status register |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data (combinational on address) |
| irq_o | output | 1 | Interrupt, completion or collision flag set |

## Verification
SCK, select and MOSI each pass three register stages before they act, so a serial edge takes effect about three system clocks after the pin moves. The bench master holds every SCK half period for eight clocks. It samples MISO at the opposite edge, so MISO has settled long before it is read. After deselecting, the bench waits sixteen clocks before any status read. Host reads are launched on a falling clock edge, and read data is sampled one time step later, before the rising edge where the read's side effect happens. This makes a clear due on the access after the status read, never the read itself.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef struct packed {
    logic wcol;
    logic done;
  } stat_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= {STAGES{RST_VAL}};
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_edge.sv
module spi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic sck_s_i,
  input  logic ssel_s_i,
  output logic sel_o,
  output logic start_o,
  output logic samp_o,
  output logic shift_o
);
  logic sck_q, ssel_q;
  logic moved, lead, trail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      ssel_q <= 1'b1;
    end else begin
      sck_q  <= sck_s_i;
      ssel_q <= ssel_s_i;
    end
  end

  assign sel_o   = ~ssel_s_i;
  assign start_o = ssel_q & ~ssel_s_i;
  assign moved   = sel_o & (sck_s_i ^ sck_q);
  // leading edge leaves the idle level, trailing edge returns to it
  assign lead    = moved & (sck_s_i != cpol_i);
  assign trail   = moved & (sck_s_i == cpol_i);
  assign samp_o  = cpha_i ? trail : lead;
  assign shift_o = cpha_i ? lead  : trail;
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int unsigned DATA_W   = 16,
  parameter logic        IDLE_BIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpha_i,
  input  logic              wide_i,
  input  logic              sel_i,
  input  logic              start_i,
  input  logic              samp_i,
  input  logic              shift_i,
  input  logic              mosi_s_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              tx_valid_i,
  output logic              tx_take_o,
  output logic              rx_done_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(DATA_W/2 - 1);
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};

  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, load_val;
  logic [CNT_W-1:0]  cnt;
  logic              fresh, last, load;

  assign last     = samp_i & (cnt == (wide_i ? LAST_WIDE : LAST_NARROW));
  assign load     = start_i | last;
  assign load_val = tx_valid_i ? tx_word_i : {DATA_W{IDLE_BIT}};
  assign rx_next  = {rx_sh[DATA_W-2:0], mosi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh <= {DATA_W{IDLE_BIT}};
      rx_sh <= '0;
      cnt   <= '0;
      fresh <= 1'b0;
    end else if (start_i) begin
      tx_sh <= load_val;
      cnt   <= '0;
      // phase 1 skips the first leading edge: MSB is already on the pin
      fresh <= cpha_i;
    end else if (!sel_i) begin
      cnt   <= '0;
      fresh <= 1'b0;
    end else if (samp_i) begin
      rx_sh <= rx_next;
      if (last) begin
        cnt   <= '0;
        tx_sh <= load_val;
        fresh <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (shift_i) begin
      if (fresh) fresh <= 1'b0;
      else       tx_sh <= tx_sh << 1;
    end
  end

  assign tx_take_o = load & tx_valid_i;
  assign rx_done_o = last & ~start_i;
  assign rx_word_o = wide_i ? rx_next : (rx_next & NARROW_MASK);
  assign miso_oe_o = sel_i;
  assign miso_o    = sel_i ? tx_sh[wide_i ? DATA_W-1 : DATA_W/2-1] : IDLE_BIT;
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_slave_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              tx_take_i,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              tx_valid_o,
  output stat_t             stat_o
);
  logic [DATA_W-1:0] rx_buf;
  logic              arm;
  logic              stat_rd, data_acc, data_wr, coll, clr;
  stat_t             stat_q;

  assign stat_rd  = req_i & ~we_i & (addr_i == ADDR_STAT);
  assign data_acc = req_i & (addr_i == ADDR_DATA);
  assign data_wr  = data_acc & we_i;
  assign coll     = data_wr & busy_i;
  assign clr      = data_acc & arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_word_o  <= '0;
      tx_valid_o <= 1'b0;
      rx_buf     <= '0;
      arm        <= 1'b0;
      stat_q     <= '0;
    end else begin
      if (data_wr && !busy_i) begin
        tx_word_o  <= wdata_i;
        tx_valid_o <= 1'b1;
      end else if (tx_take_i) begin
        tx_valid_o <= 1'b0;
      end
      if (rx_done_i) rx_buf <= rx_word_i;
      // new events win over a clear in the same cycle
      stat_q.done <= rx_done_i | (stat_q.done & ~clr);
      stat_q.wcol <= coll      | (stat_q.wcol & ~clr);
      if (stat_rd)       arm <= stat_q.done | stat_q.wcol;
      else if (data_acc) arm <= 1'b0;
    end
  end

  assign stat_o  = stat_q;
  assign rdata_o = (addr_i == ADDR_STAT) ? {{(DATA_W-2){1'b0}}, stat_q} : rx_buf;
endmodule

// File: rtl/spi_slave_flags.sv
module spi_slave_flags
  import spi_slave_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE_BIT    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic              cfg_wide_i,
  input  logic              sck_i,
  input  logic              ssel_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic              host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              irq_o
);
  logic              sck_s, ssel_s, mosi_s;
  logic              sel_act, start, samp, shift;
  logic              tx_take, rx_done, tx_valid;
  logic [DATA_W-1:0] rx_word, tx_word;
  stat_t             stat;
  logic              flag_done, flag_wcol;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({sck_i, ssel_ni, mosi_i}),
    .q_o ({sck_s, ssel_s, mosi_s})
  );

  spi_edge u_edge (
    .clk_i, .rst_ni,
    .cpol_i   (cfg_cpol_i),
    .cpha_i   (cfg_cpha_i),
    .sck_s_i  (sck_s),
    .ssel_s_i (ssel_s),
    .sel_o    (sel_act),
    .start_o  (start),
    .samp_o   (samp),
    .shift_o  (shift)
  );

  spi_shift #(.DATA_W(DATA_W), .IDLE_BIT(IDLE_BIT)) u_shift (
    .clk_i, .rst_ni,
    .cpha_i     (cfg_cpha_i),
    .wide_i     (cfg_wide_i),
    .sel_i      (sel_act),
    .start_i    (start),
    .samp_i     (samp),
    .shift_i    (shift),
    .mosi_s_i   (mosi_s),
    .tx_word_i  (tx_word),
    .tx_valid_i (tx_valid),
    .tx_take_o  (tx_take),
    .rx_done_o  (rx_done),
    .rx_word_o  (rx_word),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o)
  );

  spi_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .req_i      (host_req_i),
    .we_i       (host_we_i),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .rdata_o    (host_rdata_o),
    .busy_i     (sel_act),
    .rx_done_i  (rx_done),
    .rx_word_i  (rx_word),
    .tx_take_i  (tx_take),
    .tx_word_o  (tx_word),
    .tx_valid_o (tx_valid),
    .stat_o     (stat)
  );

  assign flag_done = stat.done;
  assign flag_wcol = stat.wcol;
  assign irq_o     = flag_done | flag_wcol;
endmodule

// File: rtl/spi_slave_flags_chk.sv
module spi_slave_flags_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ssel_ni,
  input logic              host_req_i,
  input logic              host_we_i,
  input logic              host_addr_i,
  input logic [1:0]        stat_bits,
  input logic              irq_o,
  input logic              miso_oe_o,
  input logic              sel_act,
  input logic              flag_done,
  input logic              flag_wcol,
  input logic [DATA_W-1:0] tx_word
);
  logic coll_wr, data_acc, stat_rd;
  assign data_acc = host_req_i && (host_addr_i == 1'b0);
  assign coll_wr  = data_acc && host_we_i && sel_act;
  assign stat_rd  = host_req_i && !host_we_i && host_addr_i;

  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ssel_ni && $past(ssel_ni) && $past(ssel_ni, 2) |-> !miso_oe_o); // R1

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_done && !data_acc |=> flag_done); // R5

  AST_WCOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_wr |=> flag_wcol); // R6

  AST_WCOL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_wr |=> $stable(tx_word)); // R6

  AST_WCOL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wcol && !data_acc |=> flag_wcol); // R7

  AST_IRQ_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |-> irq_o == (stat_bits[0] | stat_bits[1])); // R10
endmodule

bind spi_slave_flags spi_slave_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ssel_ni     (ssel_ni),
  .host_req_i  (host_req_i),
  .host_we_i   (host_we_i),
  .host_addr_i (host_addr_i),
  .stat_bits   (host_rdata_o[1:0]),
  .irq_o       (irq_o),
  .miso_oe_o   (miso_oe_o),
  .sel_act     (sel_act),
  .flag_done   (flag_done),
  .flag_wcol   (flag_wcol),
  .tx_word     (tx_word)
);

// File: tb/sim_spi_slave_flags.sv
module sim_spi_slave_flags;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cpol = 1'b0, cpha = 1'b0, wide = 1'b0;
  logic        sck = 1'b0, ssel_n = 1'b1, mosi = 1'b0;
  logic        miso, miso_oe, irq;
  logic        req = 1'b0, we = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0, rdata;

  spi_slave_flags u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_cpol_i(cpol), .cfg_cpha_i(cpha), .cfg_wide_i(wide),
    .sck_i(sck), .ssel_ni(ssel_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe),
    .host_req_i(req), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  logic [15:0] exp_q[$], act_q[$];
  string       tag_q[$];

  task automatic check(string req_tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic host_wr(input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 1'b0; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic sel_on();
    @(negedge clk);
    sck = cpol;
    ssel_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic sel_off();
    wait_clk(HALF);
    ssel_n = 1'b1;
    wait_clk(2*HALF);
  endtask

  // master side of one character; returns bits seen on MISO
  task automatic spi_char(input logic [15:0] tx, input int nb, output logic [15:0] got);
    got = '0;
    for (int i = nb-1; i >= 0; i--) begin
      if (!cpha) begin
        mosi = tx[i];
        wait_clk(HALF);
        sck = ~cpol;
        got = {got[14:0], miso};
        wait_clk(HALF);
        sck = cpol;
      end else begin
        sck = ~cpol;
        mosi = tx[i];
        wait_clk(HALF);
        sck = cpol;
        got = {got[14:0], miso};
        wait_clk(HALF);
      end
    end
    if (!cpha) wait_clk(HALF);
  endtask

  // driver: expected MISO word to the scoreboard, then run the character
  task automatic xfer(input logic [15:0] tx, input logic [15:0] exp_miso, input int nb, input string t);
    logic [15:0] g;
    exp_q.push_back(exp_miso);
    tag_q.push_back(t);
    sel_on();
    spi_char(tx, nb, g);
    sel_off();
    act_q.push_back(g);
  endtask

  // monitor
  initial begin
    forever begin
      wait (act_q.size() != 0);
      check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
    end
  end

  task automatic finish_run();
    wait_clk(4);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    wait_clk(150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d, g1, g2;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);

    // R12 reset state
    host_rd(1'b1, d); check("R12 status", d, 16'h0000);
    host_rd(1'b0, d); check("R12 data", d, 16'h0000);
    check("R12 irq", {15'b0, irq}, 16'h0000);
    check("R12 oe", {15'b0, miso_oe}, 16'h0000);

    // R3 all four modes, 8-bit, R2/R5/R8 along the way
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0]; wide = 1'b0;
      wait_clk(4);
      host_wr(16'hFFA5 ^ 16'(m * 17));
      xfer(16'h003C + 16'(m), 16'h00A5 ^ 16'(m * 17), 8, "R3 R8 miso");
      host_rd(1'b1, d); check("R5 done set", d, 16'h0001);
      check("R10 irq high", {15'b0, irq}, 16'h0001);
      host_rd(1'b0, d); check("R2 rx", d, 16'h003C + 16'(m));
      host_rd(1'b1, d); check("R5 cleared", d, 16'h0000);
      check("R10 irq low", {15'b0, irq}, 16'h0000);
    end

    // R4 16-bit mode, mode 3; no completion at bit 8
    cpol = 1'b1; cpha = 1'b1; wide = 1'b1;
    wait_clk(4);
    host_wr(16'hBEEF);
    sel_on();
    check("R1 oe selected", {15'b0, miso_oe}, 16'h0001);
    spi_char(16'h0012, 8, g1);
    host_rd(1'b1, d); check("R4 no done mid", d, 16'h0000);
    spi_char(16'h0034, 8, g2);
    sel_off();
    check("R4 miso16", {g1[7:0], g2[7:0]}, 16'hBEEF);
    check("R1 oe deselected", {15'b0, miso_oe}, 16'h0000);
    check("R1 idle level", {15'b0, miso}, 16'h0000);
    host_rd(1'b1, d); check("R4 done", d, 16'h0001);
    host_rd(1'b0, d); check("R4 rx16", d, 16'h1234);

    // R8 no preload -> idle
    cpol = 1'b0; cpha = 1'b0; wide = 1'b0;
    wait_clk(4);
    xfer(16'h0081, 16'h0000, 8, "R8 idle");
    // R5 data access without status read keeps flag
    host_rd(1'b0, d); check("R2 rx idle run", d, 16'h0081);
    host_rd(1'b1, d); check("R5 kept", d, 16'h0001);
    host_rd(1'b0, d);
    host_rd(1'b1, d); check("R5 clear seq", d, 16'h0000);

    // R6/R7 collision mid character
    host_wr(16'h005A);
    fork
      xfer(16'h0066, 16'h005A, 8, "R6 inflight intact");
      begin wait_clk(HALF*6); host_wr(16'h0077); end
    join
    host_rd(1'b1, d); check("R6 wcol+done", d, 16'h0003);
    check("R10 irq wcol", {15'b0, irq}, 16'h0001);
    host_rd(1'b0, d); check("R2 rx coll", d, 16'h0066);
    host_rd(1'b1, d); check("R7 cleared", d, 16'h0000);
    xfer(16'h0001, 16'h0000, 8, "R6 write dropped");
    host_rd(1'b1, d); host_rd(1'b0, d);

    // R9 abort after 3 bits
    host_wr(16'h00F0);
    sel_on();
    spi_char(16'h0005, 3, g1);
    sel_off();
    host_rd(1'b1, d); check("R9 no done", d, 16'h0000);
    xfer(16'h00C9, 16'h0000, 8, "R9 restart miso");
    host_rd(1'b1, d); check("R9 done", d, 16'h0001);
    host_rd(1'b0, d); check("R9 rx", d, 16'h00C9);

    // R11 back to back under held select
    host_wr(16'h00C3);
    sel_on();
    spi_char(16'h0011, 8, g1);
    host_rd(1'b1, d); check("R11 first done", d, 16'h0001);
    spi_char(16'h0022, 8, g2);
    sel_off();
    check("R11 first miso", g1, 16'h00C3);
    check("R11 second idle", g2, 16'h0000);
    host_rd(1'b0, d); check("R11 rx second", d, 16'h0022);
    host_rd(1'b1, d); check("R11 cleared", d, 16'h0000);

    wait (act_q.size() == 0);
    finish_run();
  end
endmodule